// File: doc/BRIEF.md
# Serial DMA Channel Command Controller

This block sequences one serial DMA channel on behalf of a CPU. It holds a small command word and two first-descriptor pointers, one per direction, and drives two engines, one for transmit and one for receive. Each engine walks a descriptor chain. For every descriptor it fetches the descriptor, moves the buffer and then closes the descriptor. Descriptor memory and the buffer mover sit outside the block and are reached through plain request/acknowledge pairs.

The two directions stop in different ways. A transmit stop is graceful. The chain keeps running until the descriptor that carries the end-of-frame flag has been closed. The engine then goes idle, clears its own command bits and raises a sticky completion flag that drives a level interrupt. A receive abort is abrupt. One cycle after the abort bit becomes visible, the receive engine is idle and closes no descriptor. Hardware then clears the abort bit, and the CPU polls bit 15 of the command word to see that the abort has finished. To restart either direction, the CPU writes a fresh first pointer and then sets the enable bit.

Top module: `sdma_cmd_ctrl`

## Requirements
- R1: After synchronous reset, `cmd_status` is 0, `irq` is low, no request output is high, and both state outputs read IDLE. The state encoding is IDLE=0, FETCH=1, TRANSFER=2, CLOSE=3.
- R2: When `cpu_we` is high and `cpu_sel`=0, a 1 in data bit 0 (tx enable), bit 1 (tx stop), bit 4 (rx enable) or bit 15 (rx abort) sets that bit of `cmd_status`, and a 0 has no effect. A 1 in bit 8 clears the stop-complete flag. `cpu_sel`=1 loads the transmit first pointer and `cpu_sel`=2 loads the receive first pointer.
- R3: An enabled engine with a nonzero first pointer loops through FETCH (request at the current address), TRANSFER and CLOSE (close request at the same address). On the close acknowledge it fetches the next pointer. If the next pointer is zero, it goes to IDLE and clears its enable bit without raising an interrupt.
- R4: If tx enable is set while the transmit first pointer is zero, the engine stays IDLE and bit 0 reads 0 one cycle after it first reads 1.
- R5: While tx stop is set, transmission continues through descriptors whose last flag is 0. It ends only at the close acknowledge of a descriptor whose last flag is 1. The transmit engine never goes from FETCH or TRANSFER straight to IDLE.
- R6: Completion of a transmit stop clears bits 0 and 1 and sets bit 8 on the same clock edge. A stop requested while the transmitter is idle completes on the next edge.
- R7: Bit 8 stays set until a command write with data bit 8 = 1. `irq` equals bit 8.
- R8: One cycle after bit 15 reads 1, in any receive state, the receive engine is IDLE and bits 15 and 4 read 0.
- R9: While bit 15 is set, `rx_close_req` is low, so an abort closes no descriptor.
- R10: After a stop or an abort, writing a new first pointer and then setting enable starts fetching at the new pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_sel | input | 2 | Write target: 0 command, 1 tx first pointer, 2 rx first pointer |
| cpu_wdata | input | ADDR_W | CPU write data |
| cmd_status | output | 16 | Command and status word |
| irq | output | 1 | Level interrupt, stop complete |
| tx_desc_req | output | 1 | Transmit descriptor fetch request |
| tx_desc_addr | output | ADDR_W | Current transmit descriptor address |
| tx_desc_ack | input | 1 | Transmit descriptor fetch acknowledge |
| tx_desc_last | input | 1 | Fetched descriptor ends the frame |
| tx_desc_next | input | ADDR_W | Fetched next-descriptor pointer |
| tx_xfer_req | output | 1 | Transmit buffer move request |
| tx_xfer_done | input | 1 | Transmit buffer move finished |
| tx_close_req | output | 1 | Transmit descriptor close request |
| tx_close_ack | input | 1 | Transmit close acknowledge |
| tx_state | output | 2 | Transmit engine state |
| rx_desc_req | output | 1 | Receive descriptor fetch request |
| rx_desc_addr | output | ADDR_W | Current receive descriptor address |
| rx_desc_ack | input | 1 | Receive descriptor fetch acknowledge |
| rx_desc_next | input | ADDR_W | Fetched next-descriptor pointer |
| rx_xfer_req | output | 1 | Receive buffer move request |
| rx_xfer_done | input | 1 | Receive buffer move finished |
| rx_close_req | output | 1 | Receive descriptor close request |
| rx_close_ack | input | 1 | Receive close acknowledge |
| rx_state | output | 2 | Receive engine state |

## Verification
The bench builds the block with ADDR_W set to 16. That keeps every pointer small enough that a 16-entry descriptor table, indexed by address bits 7:4, can model chains with mixed last flags and a zero terminator. The narrow width leaves all 16 command bits intact, including bit 15. The stall controls on the bench's receive responder hold the engine in TRANSFER or in CLOSE. This makes an abort in the middle of a buffer and an abort while a close is pending both reachable at a known cycle.

// File: rtl/sdma_cmd_pkg.sv
package sdma_cmd_pkg;

    localparam int CMD_W = 16;

    // command word bit positions (bit 15 is polled for abort completion)
    localparam int B_TX_EN    = 0;
    localparam int B_TX_STOP  = 1;
    localparam int B_RX_EN    = 4;
    localparam int B_DONE     = 8;
    localparam int B_RX_ABORT = 15;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_XFER  = 2'd2,
        ST_CLOSE = 2'd3
    } eng_state_e;

    typedef enum logic [1:0] {
        SEL_CMD   = 2'd0,
        SEL_TXPTR = 2'd1,
        SEL_RXPTR = 2'd2
    } cpu_sel_e;

    // pulses from an engine back to the command word
    typedef struct packed {
        logic clr_en;
        logic clr_halt;
    } eng_ctl_t;

    function automatic logic is_busy(eng_state_e s);
        return s != ST_IDLE;
    endfunction

endpackage

// File: rtl/sdma_engine.sv
module sdma_engine
    import sdma_cmd_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter bit IMMEDIATE_HALT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              halt_i,
    input  logic [ADDR_W-1:0] first_ptr_i,
    output logic              desc_req_o,
    output logic [ADDR_W-1:0] desc_addr_o,
    input  logic              desc_ack_i,
    input  logic              desc_last_i,
    input  logic [ADDR_W-1:0] desc_next_i,
    output logic              xfer_req_o,
    input  logic              xfer_done_i,
    output logic              close_req_o,
    input  logic              close_ack_i,
    output eng_state_e        state_o,
    output eng_ctl_t          ctl_o
);

    eng_state_e        st, st_n;
    logic [ADDR_W-1:0] cur_ptr, next_q;
    logic              last_q;
    logic              ptr_load;
    logic              abort_now;

    // the halt input is either an immediate abort or a frame-end stop
    generate
        if (IMMEDIATE_HALT) begin : g_abort
            assign abort_now = halt_i;

            p_abort_idle_r8: assert property (@(posedge clk) disable iff (rst)
                halt_i |=> (st == ST_IDLE));
        end else begin : g_graceful
            assign abort_now = 1'b0;

            p_no_early_idle_r5: assert property (@(posedge clk) disable iff (rst)
                (st == ST_FETCH || st == ST_XFER) |=> (st != ST_IDLE));
        end
    endgenerate

    always_comb begin
        st_n     = st;
        ptr_load = 1'b0;
        ctl_o    = '0;
        case (st)
            ST_IDLE: begin
                if (halt_i) begin
                    ctl_o = '{clr_en: 1'b1, clr_halt: 1'b1};
                end else if (en_i) begin
                    if (first_ptr_i == '0) begin
                        ctl_o.clr_en = 1'b1;
                    end else begin
                        st_n     = ST_FETCH;
                        ptr_load = 1'b1;
                    end
                end
            end
            ST_FETCH: if (desc_ack_i)  st_n = ST_XFER;
            ST_XFER:  if (xfer_done_i) st_n = ST_CLOSE;
            ST_CLOSE: begin
                if (close_ack_i) begin
                    if (last_q && halt_i) begin
                        st_n  = ST_IDLE;
                        ctl_o = '{clr_en: 1'b1, clr_halt: 1'b1};
                    end else if (next_q == '0) begin
                        st_n         = ST_IDLE;
                        ctl_o.clr_en = 1'b1;
                    end else begin
                        st_n = ST_FETCH;
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
        if (abort_now && is_busy(st)) begin
            st_n     = ST_IDLE;
            ptr_load = 1'b0;
            ctl_o    = '{clr_en: 1'b1, clr_halt: 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cur_ptr <= '0;
            next_q  <= '0;
            last_q  <= 1'b0;
        end else begin
            st <= st_n;
            if (ptr_load) cur_ptr <= first_ptr_i;
            if (st == ST_FETCH && desc_ack_i && !abort_now) begin
                last_q <= desc_last_i;
                next_q <= desc_next_i;
            end
            if (st == ST_CLOSE && st_n == ST_FETCH) cur_ptr <= next_q;
        end
    end

    assign desc_req_o  = (st == ST_FETCH) && !abort_now;
    assign xfer_req_o  = (st == ST_XFER)  && !abort_now;
    assign close_req_o = (st == ST_CLOSE) && !abort_now;
    assign desc_addr_o = cur_ptr;
    assign state_o     = st;

    p_fetch_start_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && en_i && !halt_i && first_ptr_i != '0) |=> (st == ST_FETCH));

endmodule

// File: rtl/sdma_cmd_ctrl.sv
module sdma_cmd_ctrl
    import sdma_cmd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_sel,
    input  logic [ADDR_W-1:0] cpu_wdata,
    output logic [15:0]       cmd_status,
    output logic              irq,
    output logic              tx_desc_req,
    output logic [ADDR_W-1:0] tx_desc_addr,
    input  logic              tx_desc_ack,
    input  logic              tx_desc_last,
    input  logic [ADDR_W-1:0] tx_desc_next,
    output logic              tx_xfer_req,
    input  logic              tx_xfer_done,
    output logic              tx_close_req,
    input  logic              tx_close_ack,
    output logic [1:0]        tx_state,
    output logic              rx_desc_req,
    output logic [ADDR_W-1:0] rx_desc_addr,
    input  logic              rx_desc_ack,
    input  logic [ADDR_W-1:0] rx_desc_next,
    output logic              rx_xfer_req,
    input  logic              rx_xfer_done,
    output logic              rx_close_req,
    input  logic              rx_close_ack,
    output logic [1:0]        rx_state
);

    logic              tx_en, tx_stop, rx_en, rx_abort, stop_done;
    logic [ADDR_W-1:0] tx_ptr, rx_ptr;
    eng_ctl_t          tx_ctl, rx_ctl;
    eng_state_e        tx_st, rx_st;
    logic              cmd_wr;

    assign cmd_wr = cpu_we && (cpu_sel == SEL_CMD);

    // hardware clears first, CPU sets afterwards so a same-edge write wins
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_en     <= 1'b0;
            tx_stop   <= 1'b0;
            rx_en     <= 1'b0;
            rx_abort  <= 1'b0;
            stop_done <= 1'b0;
            tx_ptr    <= '0;
            rx_ptr    <= '0;
        end else begin
            if (tx_ctl.clr_en)   tx_en    <= 1'b0;
            if (tx_ctl.clr_halt) tx_stop  <= 1'b0;
            if (rx_ctl.clr_en)   rx_en    <= 1'b0;
            if (rx_ctl.clr_halt) rx_abort <= 1'b0;
            if (cmd_wr && cpu_wdata[B_DONE]) stop_done <= 1'b0;
            if (tx_ctl.clr_halt) stop_done <= 1'b1;
            if (cmd_wr) begin
                if (cpu_wdata[B_TX_EN])    tx_en    <= 1'b1;
                if (cpu_wdata[B_TX_STOP])  tx_stop  <= 1'b1;
                if (cpu_wdata[B_RX_EN])    rx_en    <= 1'b1;
                if (cpu_wdata[B_RX_ABORT]) rx_abort <= 1'b1;
            end
            if (cpu_we && cpu_sel == SEL_TXPTR) tx_ptr <= cpu_wdata;
            if (cpu_we && cpu_sel == SEL_RXPTR) rx_ptr <= cpu_wdata;
        end
    end

    always_comb begin
        cmd_status             = '0;
        cmd_status[B_TX_EN]    = tx_en;
        cmd_status[B_TX_STOP]  = tx_stop;
        cmd_status[B_RX_EN]    = rx_en;
        cmd_status[B_DONE]     = stop_done;
        cmd_status[B_RX_ABORT] = rx_abort;
    end

    assign irq      = stop_done;
    assign tx_state = tx_st;
    assign rx_state = rx_st;

    sdma_engine #(.ADDR_W(ADDR_W), .IMMEDIATE_HALT(1'b0)) u_tx (
        .clk(clk), .rst(rst), .en_i(tx_en), .halt_i(tx_stop), .first_ptr_i(tx_ptr),
        .desc_req_o(tx_desc_req), .desc_addr_o(tx_desc_addr), .desc_ack_i(tx_desc_ack),
        .desc_last_i(tx_desc_last), .desc_next_i(tx_desc_next),
        .xfer_req_o(tx_xfer_req), .xfer_done_i(tx_xfer_done),
        .close_req_o(tx_close_req), .close_ack_i(tx_close_ack),
        .state_o(tx_st), .ctl_o(tx_ctl)
    );

    sdma_engine #(.ADDR_W(ADDR_W), .IMMEDIATE_HALT(1'b1)) u_rx (
        .clk(clk), .rst(rst), .en_i(rx_en), .halt_i(rx_abort), .first_ptr_i(rx_ptr),
        .desc_req_o(rx_desc_req), .desc_addr_o(rx_desc_addr), .desc_ack_i(rx_desc_ack),
        .desc_last_i(1'b0), .desc_next_i(rx_desc_next),
        .xfer_req_o(rx_xfer_req), .xfer_done_i(rx_xfer_done),
        .close_req_o(rx_close_req), .close_ack_i(rx_close_ack),
        .state_o(rx_st), .ctl_o(rx_ctl)
    );

    p_ptr_zero_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_st == ST_IDLE && tx_en && !tx_stop && tx_ptr == '0 && !cmd_wr) |=> !tx_en);

    p_stop_done_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_ctl.clr_halt && !cmd_wr) |=> (stop_done && !tx_en && !tx_stop));

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (stop_done && !(cmd_wr && cpu_wdata[B_DONE])) |=> stop_done);

    p_abort_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_abort && !cmd_wr) |=> (!rx_abort && !rx_en));

    p_abort_no_close_r9: assert property (@(posedge clk) disable iff (rst)
        rx_close_req |-> !rx_abort);

endmodule

// File: tb/sim_sdma_cmd_ctrl.sv
module sim_sdma_cmd_ctrl;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_we = 1'b0;
    logic [1:0]    cpu_sel = 2'd0;
    logic [AW-1:0] cpu_wdata = '0;
    logic [15:0]   cmd_status;
    logic          irq;
    logic          tx_desc_req, tx_xfer_req, tx_close_req;
    logic [AW-1:0] tx_desc_addr, tx_desc_next;
    logic          tx_desc_ack = 1'b0, tx_xfer_done = 1'b0, tx_close_ack = 1'b0, tx_desc_last;
    logic [1:0]    tx_state, rx_state;
    logic          rx_desc_req, rx_xfer_req, rx_close_req;
    logic [AW-1:0] rx_desc_addr, rx_desc_next;
    logic          rx_desc_ack = 1'b0, rx_xfer_done = 1'b0, rx_close_ack = 1'b0;

    logic          hold_rx_xfer = 1'b0, hold_rx_close = 1'b0;
    logic          tx_last_t [16];
    logic [AW-1:0] tx_next_t [16];
    logic [AW-1:0] rx_next_t [16];
    logic [AW-1:0] exp_tx [$];
    logic [AW-1:0] exp_rx [$];
    int            n_checks = 0, n_fail = 0;
    bit            finished = 1'b0;

    always #10 clk = ~clk;

    sdma_cmd_ctrl #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
        .cmd_status(cmd_status), .irq(irq),
        .tx_desc_req(tx_desc_req), .tx_desc_addr(tx_desc_addr), .tx_desc_ack(tx_desc_ack),
        .tx_desc_last(tx_desc_last), .tx_desc_next(tx_desc_next),
        .tx_xfer_req(tx_xfer_req), .tx_xfer_done(tx_xfer_done),
        .tx_close_req(tx_close_req), .tx_close_ack(tx_close_ack), .tx_state(tx_state),
        .rx_desc_req(rx_desc_req), .rx_desc_addr(rx_desc_addr), .rx_desc_ack(rx_desc_ack),
        .rx_desc_next(rx_desc_next),
        .rx_xfer_req(rx_xfer_req), .rx_xfer_done(rx_xfer_done),
        .rx_close_req(rx_close_req), .rx_close_ack(rx_close_ack), .rx_state(rx_state)
    );

    // descriptor memory model
    assign tx_desc_last = tx_last_t[tx_desc_addr[7:4]];
    assign tx_desc_next = tx_next_t[tx_desc_addr[7:4]];
    assign rx_desc_next = rx_next_t[rx_desc_addr[7:4]];

    always @(negedge clk) begin
        tx_desc_ack  <= tx_desc_req;
        tx_xfer_done <= tx_xfer_req;
        tx_close_ack <= tx_close_req;
        rx_desc_ack  <= rx_desc_req;
        rx_xfer_done <= rx_xfer_req && !hold_rx_xfer;
        rx_close_ack <= rx_close_req && !hold_rx_close;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: every completed close handshake pops one item
    always @(negedge clk) begin
        #1;
        if (!rst && tx_close_req && tx_close_ack) begin
            if (exp_tx.size() == 0) check(1'b0, "R5", "unexpected tx close", tx_desc_addr, 0);
            else begin
                logic [AW-1:0] e;
                e = exp_tx.pop_front();
                check(tx_desc_addr == e, "R3", "tx close address", tx_desc_addr, e);
            end
        end
        if (!rst && rx_close_req && rx_close_ack) begin
            if (exp_rx.size() == 0) check(1'b0, "R9", "unexpected rx close", rx_desc_addr, 0);
            else begin
                logic [AW-1:0] e;
                e = exp_rx.pop_front();
                check(rx_desc_addr == e, "R3", "rx close address", rx_desc_addr, e);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #2;
    endtask

    task automatic cpu_write(input logic [1:0] sel, input logic [AW-1:0] data);
        cpu_we = 1'b1; cpu_sel = sel; cpu_wdata = data;
        tick();
        cpu_we = 1'b0; cpu_wdata = '0;
    endtask

    task automatic expect_close(input bit rx, input logic [AW-1:0] a);
        if (rx) exp_rx.push_back(a);
        else    exp_tx.push_back(a);
    endtask

    task automatic wait_idle(input bit rx, input string req);
        int n = 0;
        do begin
            tick();
            n++;
        end while (!((rx ? rx_state : tx_state) == 2'd0 &&
                     (rx ? exp_rx.size() : exp_tx.size()) == 0) && n < 200);
        check(n < 200, req, "engine reached idle with queue drained", n, 200);
    endtask

    task automatic wait_rx_state(input logic [1:0] s);
        int n = 0;
        while (rx_state != s && n < 50) begin
            tick();
            n++;
        end
        check(rx_state == s, "R8", "rx reached target state", rx_state, s);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            tx_last_t[i] = 1'b0; tx_next_t[i] = '0; rx_next_t[i] = '0;
        end
        // tx chain 10 -> 20(last) -> 30 -> 40(last) -> end
        tx_next_t[1] = 16'h20;
        tx_next_t[2] = 16'h30; tx_last_t[2] = 1'b1;
        tx_next_t[3] = 16'h40;
        tx_last_t[4] = 1'b1;
        // rx chain 80 -> 90 -> A0 -> end
        rx_next_t[8] = 16'h90;
        rx_next_t[9] = 16'hA0;

        repeat (3) tick();
        rst = 1'b0;
        tick();
        check(cmd_status == 16'h0, "R1", "cmd_status after reset", cmd_status, 0);
        check(irq == 1'b0, "R1", "irq after reset", irq, 0);
        check(tx_state == 2'd0 && rx_state == 2'd0, "R1", "states after reset",
              {tx_state, rx_state}, 0);
        check(!tx_desc_req && !rx_desc_req && !tx_close_req && !rx_close_req, "R1",
              "no requests after reset", 0, 0);

        // R4: enable with zero pointer
        cpu_write(2'd0, 16'h0001);
        check(cmd_status[0] == 1'b1, "R2", "tx enable bit set by write", cmd_status[0], 1);
        tick();
        check(cmd_status[0] == 1'b0, "R4", "enable dropped with zero pointer", cmd_status[0], 0);
        check(tx_state == 2'd0, "R4", "tx stays idle", tx_state, 0);

        // R3: full chain without stop
        cpu_write(2'd1, 16'h10);
        expect_close(1'b0, 16'h10); expect_close(1'b0, 16'h20);
        expect_close(1'b0, 16'h30); expect_close(1'b0, 16'h40);
        cpu_write(2'd0, 16'h0001);
        wait_idle(1'b0, "R3");
        check(cmd_status[0] == 1'b0, "R3", "enable cleared at chain end", cmd_status[0], 0);
        check(irq == 1'b0, "R3", "no interrupt at chain end", irq, 0);

        // R5/R6: graceful stop ends after the first last-flagged descriptor
        cpu_write(2'd1, 16'h10);
        expect_close(1'b0, 16'h10); expect_close(1'b0, 16'h20);
        cpu_write(2'd0, 16'h0001);
        cpu_write(2'd0, 16'h0002);
        check(cmd_status[1] == 1'b1, "R5", "stop bit pending while running", cmd_status[1], 1);
        wait_idle(1'b0, "R5");
        repeat (4) tick();
        check(tx_state == 2'd0, "R5", "tx idle after frame end", tx_state, 0);
        check(cmd_status[1:0] == 2'b00, "R6", "enable and stop cleared", cmd_status[1:0], 0);
        check(cmd_status[8] == 1'b1 && irq == 1'b1, "R6", "stop complete flagged",
              {cmd_status[8], irq}, 2'b11);

        // R7: sticky until write-1
        repeat (5) tick();
        check(irq == 1'b1, "R7", "irq holds", irq, 1);
        cpu_write(2'd0, 16'h0000);
        check(irq == 1'b1, "R7", "write of 0 leaves irq", irq, 1);
        cpu_write(2'd0, 16'h0100);
        check(irq == 1'b0 && cmd_status[8] == 1'b0, "R7", "write-1 clears flag", irq, 0);

        // R10: restart tx from new pointer
        cpu_write(2'd1, 16'h30);
        expect_close(1'b0, 16'h30); expect_close(1'b0, 16'h40);
        cpu_write(2'd0, 16'h0001);
        wait_idle(1'b0, "R10");
        check(cmd_status[1:0] == 2'b00 && irq == 1'b0, "R10", "restart ran to chain end",
              {cmd_status[1:0], irq}, 0);

        // R6: stop while idle completes at once
        cpu_write(2'd0, 16'h0002);
        tick();
        check(irq == 1'b1 && cmd_status[1] == 1'b0, "R6", "idle stop completes",
              {irq, cmd_status[1]}, 2'b10);
        cpu_write(2'd0, 16'h0100);

        // R3 on receive
        cpu_write(2'd2, 16'h80);
        expect_close(1'b1, 16'h80); expect_close(1'b1, 16'h90); expect_close(1'b1, 16'hA0);
        cpu_write(2'd0, 16'h0010);
        wait_idle(1'b1, "R3");
        check(cmd_status[4] == 1'b0, "R3", "rx enable cleared at chain end", cmd_status[4], 0);

        // R8: abort during transfer
        hold_rx_xfer = 1'b1;
        cpu_write(2'd2, 16'h80);
        cpu_write(2'd0, 16'h0010);
        wait_rx_state(2'd2);
        cpu_write(2'd0, 16'h8000);
        check(cmd_status[15] == 1'b1, "R8", "abort bit visible", cmd_status[15], 1);
        tick();
        check(rx_state == 2'd0, "R8", "rx idle one cycle after abort", rx_state, 0);
        check(cmd_status[15] == 1'b0 && cmd_status[4] == 1'b0, "R8", "abort and enable cleared",
              {cmd_status[15], cmd_status[4]}, 0);
        hold_rx_xfer = 1'b0;

        // R9: abort while a close is pending
        hold_rx_close = 1'b1;
        cpu_write(2'd2, 16'h80);
        cpu_write(2'd0, 16'h0010);
        wait_rx_state(2'd3);
        cpu_write(2'd0, 16'h8000);
        check(rx_close_req == 1'b0, "R9", "close request dropped under abort", rx_close_req, 0);
        tick();
        check(rx_state == 2'd0 && cmd_status[15] == 1'b0, "R9", "abort from close state",
              {rx_state, cmd_status[15]}, 0);
        hold_rx_close = 1'b0;

        // R8: abort while idle just clears
        cpu_write(2'd0, 16'h8000);
        tick();
        check(cmd_status[15] == 1'b0, "R8", "idle abort clears", cmd_status[15], 0);

        // R10: restart rx at a new pointer
        cpu_write(2'd2, 16'h90);
        expect_close(1'b1, 16'h90); expect_close(1'b1, 16'hA0);
        cpu_write(2'd0, 16'h0010);
        wait_idle(1'b1, "R10");
        check(exp_tx.size() == 0 && exp_rx.size() == 0, "R10", "scoreboard drained",
              exp_tx.size() + exp_rx.size(), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog run did not finish actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule